// File: doc/BRIEF.md
# Phase-Staggered Five-Channel Pulse-Width DAC

This block drives five pulse-width outputs for low-cost digital-to-analog conversion. Each output carries an 8-bit duty value and repeats with a period of 256 ticks of a PWM clock. The PWM clock is the pixel clock divided by 1, 2, 4 or 8, and a 2-bit range code selects the divisor. Duty values are written through a small register port that carries a channel index and a data byte.

The five channels share one period counter, but their periods are offset. Channel n begins its period one PWM tick after channel n-1. This spreads the rising edges, so the outputs never all switch together. Each output is an open-drain pull-down enable. A value of 1 sinks the line, and a value of 0 releases it so that an external resistor can pull it high.

A written duty value is first held in a shadow register. It is copied into the channel's working register only at the start of that channel's next period, so a period is never cut short or stretched.

Top module: `pwm_stagger_dac`

## Requirements
- R1: There are five channels. A write with `wr_en` high stores `wr_data` as the 8-bit duty of the channel numbered by `wr_addr` (0 to 4).
- R2: Each channel period lasts 256 PWM ticks. For duty D, `pull_en[n]` is 0 (released) during the first D tick intervals of the period and 1 (pulled low) during the remaining 256-D.
- R3: The period of channel n starts one PWM tick after the period of channel n-1. Channel n starts its period on the tick at which the shared count equals n.
- R4: A PWM tick occurs once every 1, 2, 4 or 8 pixel clocks for `range_sel` = 00, 01, 10 or 11 respectively.
- R5: A duty value of 0 keeps the channel pulled low (`pull_en` = 1) for the whole period.
- R6: A duty written during a period has no effect on that channel until its next period starts.
- R7: After reset, every duty register, the prescaler and the period counter are 0, and all five `pull_en` bits are 1.
- R8: A write with `wr_addr` from 5 to 7 changes no duty value.
- R9: `pull_en` changes only in the pixel clock that follows a PWM tick, because each output is registered on the tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_sel | input | 2 | Prescaler range code: 00 to 11 select divide by 1, 2, 4 or 8 |
| wr_en | input | 1 | Duty write strobe |
| wr_addr | input | 3 | Channel index for the write |
| wr_data | input | 8 | Duty value to write |
| pull_en | output | 5 | Per-channel open-drain enable; 1 sinks the line |

## Verification
The bench compares the outputs on every pixel clock against a behavioural model. The stimulus runs through four duty patterns.

- Distinct duties of 0, 1, 128, 255 and 37 test the extremes of the duty range against mid values.
- Equal duties on all channels make the one-tick stagger the only difference between the outputs.
- Writes made in the middle of a period, followed by writes to unused addresses, separate a deferred update from an immediate one or from an ignored one.
- The range code is swept over all four divisors. Switching it while the block runs shows whether the tick spacing follows the code.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
    localparam int unsigned PWM_CHANNELS = 5;
    localparam int unsigned PWM_DUTY_W   = 8;
    localparam int unsigned PWM_RANGE_W  = 2;

    // Highest prescaler count value before a tick for a given range code.
    function automatic int unsigned range_limit(input int unsigned code);
        return (32'd1 << code) - 32'd1;
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned RANGE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RANGE_W-1:0] range_i,
    output logic               tick_o
);
    localparam int unsigned PRE_W = (1 << RANGE_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] lim;
    logic             tick;

    always_comb begin
        lim  = PRE_W'(pwm_dac_pkg::range_limit(int'(range_i)));
        tick = (st_q.cnt >= lim);
        st_d = st_q;
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;

    // R4: with a divisor above one, two ticks never come back to back
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && range_i != '0) |=> (!tick_o || range_i != $past(range_i)));
endmodule

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R2: the shared count advances by exactly one per tick and wraps at 256
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R9: without a tick the count holds
    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank #(
    parameter int unsigned NUM_CH = 5,
    parameter int unsigned DUTY_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              wr_addr_i,
    input  logic [DUTY_W-1:0]              wr_data_i,
    output logic [NUM_CH-1:0][DUTY_W-1:0]  duty_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][DUTY_W-1:0] duty;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic        addr_ok;

    always_comb begin
        addr_ok = (int'(wr_addr_i) < NUM_CH);
        st_d    = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en_i && addr_ok && int'(wr_addr_i) == i) begin
                st_d.duty[i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_o = st_q.duty;

    // R8: writes to unused addresses leave every shadow duty untouched
    assert_bad_addr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(wr_addr_i) >= NUM_CH) |=> $stable(duty_o));

    // R1: no write strobe, no change
    assert_no_write_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(duty_o));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int unsigned DUTY_W = 8,
    parameter int unsigned CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [DUTY_W-1:0] cnt_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pull_o
);
    localparam logic [DUTY_W-1:0] OFS = DUTY_W'(CH_IDX);

    typedef struct packed {
        logic [DUTY_W-1:0] active;
        logic              high;
    } ch_state_t;

    ch_state_t         st_d, st_q;
    logic [DUTY_W-1:0] phase;
    logic              start;
    logic [DUTY_W-1:0] eff;

    always_comb begin
        phase = cnt_i - OFS;
        start = (phase == '0);
        eff   = start ? duty_i : st_q.active;
        st_d  = st_q;
        if (tick_i) begin
            st_d.active = eff;
            st_d.high   = (phase < eff);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_o = ~st_q.high;

    // R6: the working duty only reloads on this channel's period start
    assert_reload_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && start) |=> $stable(st_q.active));

    // R5: a zero working duty pulls the line low on every tick within the period
    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !start && st_q.active == '0) |=> pull_o);

    // R9: the output moves only after a tick
    assert_out_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(pull_o));
endmodule

// File: rtl/pwm_stagger_dac.sv
module pwm_stagger_dac #(
    parameter int unsigned NUM_CH  = pwm_dac_pkg::PWM_CHANNELS,
    parameter int unsigned DUTY_W  = pwm_dac_pkg::PWM_DUTY_W,
    parameter int unsigned RANGE_W = pwm_dac_pkg::PWM_RANGE_W,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RANGE_W-1:0] range_sel,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DUTY_W-1:0]  wr_data,
    output logic [NUM_CH-1:0]  pull_en
);
    logic                          tick;
    logic [DUTY_W-1:0]             cnt;
    logic [NUM_CH-1:0][DUTY_W-1:0] shadow;

    pwm_prescaler #(.RANGE_W(RANGE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .range_i(range_sel),
        .tick_o (tick)
    );

    pwm_phase_counter #(.CNT_W(DUTY_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick),
        .cnt_o (cnt)
    );

    pwm_duty_bank #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .duty_o   (shadow)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(.DUTY_W(DUTY_W), .CH_IDX(g)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick_i(tick),
            .cnt_i (cnt),
            .duty_i(shadow[g]),
            .pull_o(pull_en[g])
        );
    end

    // R3: channel 0 and channel 1 never start a period on the same tick
    assert_stagger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0) |=> (cnt == DUTY_W'(1)));
endmodule

// File: tb/tb_pwm_stagger_dac.sv
module tb_pwm_stagger_dac;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] range_sel = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [4:0] pull_en;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R7";

    // behavioural reference state
    int m_pre = 0;
    int m_cnt = 0;
    int m_sh[5]  = '{default: 0};
    int m_act[5] = '{default: 0};
    bit m_rel[5] = '{default: 1'b0};

    pwm_stagger_dac dut (
        .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pull_en(pull_en)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0;
            for (int i = 0; i < 5; i++) begin
                m_sh[i] = 0; m_act[i] = 0; m_rel[i] = 1'b0;
            end
        end else begin
            int div;
            bit t;
            div = 1 << range_sel;
            t = (m_pre % div) == div - 1 || m_pre >= div - 1;
            if (t) begin
                for (int i = 0; i < 5; i++) begin
                    int ph;
                    ph = (m_cnt - i + 256) % 256;
                    if (ph == 0) m_act[i] = m_sh[i];
                    m_rel[i] = (ph < m_act[i]);
                end
                m_cnt = (m_cnt + 1) % 256;
                m_pre = 0;
            end else begin
                m_pre = m_pre + 1;
            end
            if (wr_en && wr_addr < 3'd5) m_sh[wr_addr] = wr_data;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [4:0] exp_v;
            for (int i = 0; i < 5; i++) exp_v[i] = ~m_rel[i];
            n_cmp++;
            if (pull_en !== exp_v) begin
                n_bad++;
                $display("FAIL %s: pull_en=%b expected %b at %0t", cur_req, pull_en, exp_v, $time);
            end
        end
    end

    task automatic write_duty(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: all lines pulled low while and after reset
        n_cmp++;
        if (pull_en !== 5'h1F) begin
            n_bad++;
            $display("FAIL R7: pull_en=%b expected %b", pull_en, 5'h1F);
        end
        rst_n = 1'b1;
        run(4);
        // R1 R2 R5: distinct duties including 0 and 255, divide by one
        cur_req = "R1/R2/R5";
        write_duty(0, 0); write_duty(1, 1); write_duty(2, 128);
        write_duty(3, 255); write_duty(4, 37);
        run(700);
        // R6: mid-period rewrite only lands at the next period start
        cur_req = "R6";
        run(60);
        write_duty(2, 10);
        write_duty(4, 200);
        run(600);
        // R8: unused addresses 5..7 change nothing
        cur_req = "R8";
        write_duty(5, 99); write_duty(6, 77); write_duty(7, 255);
        run(600);
        // R3: equal duties so only the stagger separates the outputs
        cur_req = "R3";
        for (int i = 0; i < 5; i++) write_duty(i, 128);
        run(700);
        // R4 R9: every divisor, switched while running
        cur_req = "R4/R9";
        range_sel = 2'b01; run(1200);
        range_sel = 2'b10; run(2200);
        range_sel = 2'b11; write_duty(1, 3); run(4300);
        range_sel = 2'b00; run(700);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule